// File: doc/BRIEF.md
# Power-Fail Write-Protect Supervisor

This block supervises a battery-backed static memory from inside a synchronous logic domain. Two digitized supply comparator bits come in: one says the supply is above the write-protect threshold, the other says it is above the lower level where the battery must take over. The block gates the memory's chip-enable and write-enable strobes, raises a write-protect flag and a request to tristate the data outputs, and drives a control that connects the backup battery to the array.

A one-time seal keeps the battery path open from manufacture until the supply is first seen valid. Only a dedicated factory-reset input breaks the seal again; ordinary reset leaves it alone. When the supply recovers, the block holds the memory deselected for a short enable delay. It then keeps writes locked out for a longer recovery interval before normal access resumes. A new fault during that interval restarts the interval. Both delays are parameters in clock cycles. At 125 MHz the long interval is about 15.6 million cycles and the short one about 250 thousand.

Top module: `pwrfail_guard`

## Requirements
- R1: With the seal clear, the state after reset has `wprot_o`=1, `out_hiz_o`=1, `bat_conn_o`=0, `mem_ce_o`=0 and `mem_we_o`=0.
- R2: While the seal is clear, `bat_conn_o` stays 0 even when `sup_lo_ok_i` is 0.
- R3: The seal is set the first time the synchronized `sup_ok_i` is 1. It survives `rst_n` and is cleared only by `factory_rst_n`=0.
- R4: Once `sup_ok_i` falls, `wprot_o`=1, `out_hiz_o`=1 and both memory strobes are 0 no later than the third rising clock edge. They are not yet forced after the second edge.
- R5: With the seal set, `bat_conn_o` rises by the third edge after `sup_lo_ok_i` falls, and falls by the third edge after it rises again.
- R6: After the synchronized supply becomes valid, `mem_ce_o` stays 0 and `out_hiz_o` stays 1 for `ENA_CYCLES` cycles.
- R7: `wprot_o` stays 1 for `REC_CYCLES` cycles after the synchronized supply becomes valid, and then falls.
- R8: A supply fault during the recovery interval forces protection again, and the full interval restarts when the supply returns.
- R9: In normal operation `mem_ce_o`=`req_ce_i` and `mem_we_o`=`req_ce_i`&`req_we_i`. In every other state `mem_we_o` is 0.
- R10: Both comparator inputs reach the control logic through two flip-flops, so that an input change takes effect on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| factory_rst_n | input | 1 | Active-low clear of the battery seal |
| sup_ok_i | input | 1 | Supply above the write-protect threshold |
| sup_lo_ok_i | input | 1 | Supply above the battery switch-over level |
| req_ce_i | input | 1 | Chip-enable request from the host, active high |
| req_we_i | input | 1 | Write-enable request from the host, active high |
| mem_ce_o | output | 1 | Gated chip enable to the array |
| mem_we_o | output | 1 | Gated write enable to the array |
| wprot_o | output | 1 | Write protection active |
| out_hiz_o | output | 1 | Request to tristate the data outputs |
| bat_conn_o | output | 1 | Connect the battery to the array |

## Verification
The assertions assume physically ordered comparators: whenever the supply is above the write-protect threshold, it is also above the switch-over level. They also assume the enable delay is shorter than the recovery interval. The stimulus only raises `sup_ok_i` after `sup_lo_ok_i` and drops it before. The bench pulses `factory_rst_n` only while `rst_n` is also held low, so that the seal never clears in the middle of a transition.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [2:0] {
    ST_SEALED  = 3'd0,
    ST_NORMAL  = 3'd1,
    ST_PROTECT = 3'd2,
    ST_BATTERY = 3'd3,
    ST_RECOVER = 3'd4
  } pfg_state_e;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/pfg_seal.sv
module pfg_seal (
  input  logic clk,
  input  logic factory_rst_n,
  input  logic set_i,
  output logic armed_o
);
  logic armed_q, armed_en;

  assign armed_en = set_i & ~armed_q;

  always_ff @(posedge clk or negedge factory_rst_n) begin
    if (!factory_rst_n) armed_q <= 1'b0;
    else if (armed_en)  armed_q <= 1'b1;
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/pfg_fsm.sv
module pfg_fsm
  import pfg_pkg::*;
#(
  parameter int REC_CYCLES = 64,
  parameter int ENA_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ok_s_i,
  input  logic lo_s_i,
  input  logic armed_i,
  output logic normal_o,
  output logic ce_en_o,
  output logic battery_o
);
  localparam int CW = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(REC_CYCLES - 1);
  localparam logic [CW-1:0] CNT_ENA  = CW'(ENA_CYCLES);

  pfg_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SEALED:  if (ok_s_i) state_d = ST_RECOVER;
                  else if (armed_i && !lo_s_i) state_d = ST_BATTERY;
      ST_NORMAL:  if (!ok_s_i) state_d = ST_PROTECT;
      ST_PROTECT: if (!lo_s_i) state_d = ST_BATTERY;
                  else if (ok_s_i) state_d = ST_RECOVER;
      ST_BATTERY: if (lo_s_i) state_d = ST_PROTECT;
      ST_RECOVER: if (!ok_s_i) state_d = ST_PROTECT;
                  else if (cnt_q == CNT_LAST) state_d = ST_NORMAL;
      default:    state_d = ST_PROTECT;
    endcase
  end

  assign cnt_en = (state_q == ST_RECOVER) || (cnt_q != '0);
  assign cnt_d  = (state_q == ST_RECOVER && state_d == ST_RECOVER) ? cnt_q + 1'b1 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEALED;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign normal_o  = (state_q == ST_NORMAL);
  assign ce_en_o   = normal_o || (state_q == ST_RECOVER && cnt_q >= CNT_ENA);
  assign battery_o = (state_q == ST_BATTERY) && armed_i;
endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard #(
  parameter int REC_CYCLES = 15625000,
  parameter int ENA_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic factory_rst_n,
  input  logic sup_ok_i,
  input  logic sup_lo_ok_i,
  input  logic req_ce_i,
  input  logic req_we_i,
  output logic mem_ce_o,
  output logic mem_we_o,
  output logic wprot_o,
  output logic out_hiz_o,
  output logic bat_conn_o
);
  logic [1:0] cmp_s;
  logic       armed, normal, ce_en, battery;

  // R10
  pfg_sync #(.WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sup_lo_ok_i, sup_ok_i}),
    .q_o   (cmp_s)
  );

  // R3
  pfg_seal u_seal (
    .clk           (clk),
    .factory_rst_n (factory_rst_n),
    .set_i         (cmp_s[0]),
    .armed_o       (armed)
  );

  pfg_fsm #(.REC_CYCLES(REC_CYCLES), .ENA_CYCLES(ENA_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ok_s_i    (cmp_s[0]),
    .lo_s_i    (cmp_s[1]),
    .armed_i   (armed),
    .normal_o  (normal),
    .ce_en_o   (ce_en),
    .battery_o (battery)
  );

  assign mem_ce_o   = req_ce_i & ce_en;
  assign mem_we_o   = req_ce_i & req_we_i & normal;
  assign wprot_o    = ~normal;
  assign out_hiz_o  = ~ce_en;
  assign bat_conn_o = battery;
endmodule

module pwrfail_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic factory_rst_n,
  input logic sup_ok_i,
  input logic mem_ce_o,
  input logic mem_we_o,
  input logic wprot_o,
  input logic out_hiz_o,
  input logic bat_conn_o,
  input logic armed
);
  // R9
  we_only_unprot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !wprot_o);

  // R4
  fail_forces_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sup_ok_i && $past(!sup_ok_i) && $past(!sup_ok_i, 2)) |=> (wprot_o && out_hiz_o && !mem_we_o && !mem_ce_o));

  // R5
  bat_implies_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bat_conn_o |-> (wprot_o && out_hiz_o));

  // R6
  ce_needs_drivers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_o |-> !out_hiz_o);

  // R7
  unprot_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wprot_o) |-> !out_hiz_o);

  // R3
  seal_holds_chk: assert property (@(posedge clk) disable iff (!factory_rst_n)
    !$fell(armed));
endmodule

bind pwrfail_guard pwrfail_guard_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .factory_rst_n (factory_rst_n),
  .sup_ok_i      (sup_ok_i),
  .mem_ce_o      (mem_ce_o),
  .mem_we_o      (mem_we_o),
  .wprot_o       (wprot_o),
  .out_hiz_o     (out_hiz_o),
  .bat_conn_o    (bat_conn_o),
  .armed         (armed)
);

// File: tb/pwrfail_guard_tb_top.sv
`timescale 1ns/1ps
module pwrfail_guard_tb_top;
  localparam int REC = 40;
  localparam int ENA = 10;

  logic clk = 1'b0;
  logic rst_n, factory_rst_n, sup_ok, sup_lo, req_ce, req_we;
  logic mem_ce, mem_we, wprot, hiz, bat;
  int   n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  pwrfail_guard #(.REC_CYCLES(REC), .ENA_CYCLES(ENA)) dut_i (
    .clk(clk), .rst_n(rst_n), .factory_rst_n(factory_rst_n),
    .sup_ok_i(sup_ok), .sup_lo_ok_i(sup_lo), .req_ce_i(req_ce), .req_we_i(req_we),
    .mem_ce_o(mem_ce), .mem_we_o(mem_we), .wprot_o(wprot), .out_hiz_o(hiz), .bat_conn_o(bat)
  );

  // Behavioural reference: 0 sealed,1 normal,2 protect,3 battery,4 recover
  int m_st = 0, m_cnt = 0;
  bit m_s1ok, m_s2ok, m_s1lo, m_s2lo, m_arm;
  always @(posedge clk) begin
    int nst;
    if (!factory_rst_n) m_arm = 0;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_s1ok = 0; m_s2ok = 0; m_s1lo = 0; m_s2lo = 0;
    end else begin
      nst = m_st;
      case (m_st)
        0: if (m_s2ok) nst = 4; else if (m_arm && !m_s2lo) nst = 3;
        1: if (!m_s2ok) nst = 2;
        2: if (!m_s2lo) nst = 3; else if (m_s2ok) nst = 4;
        3: if (m_s2lo) nst = 2;
        default: if (!m_s2ok) nst = 2; else if (m_cnt == REC-1) nst = 1;
      endcase
      m_cnt = (m_st == 4 && nst == 4) ? m_cnt + 1 : 0;
      if (factory_rst_n && m_s2ok) m_arm = 1;
      m_st = nst;
      m_s2ok = m_s1ok; m_s1ok = sup_ok;
      m_s2lo = m_s1lo; m_s1lo = sup_lo;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && factory_rst_n) begin
      bit en, nrm;
      nrm = (m_st == 1);
      en  = nrm || (m_st == 4 && m_cnt >= ENA);
      chk("R6 mem_ce", mem_ce, req_ce & en);
      chk("R6 out_hiz", hiz, !en);
      chk("R9 mem_we", mem_we, req_ce & req_we & nrm);
      chk("R7 wprot", wprot, !nrm);
      chk("R5 bat_conn", bat, (m_st == 3) && m_arm);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic main_seq();
    rst_n = 0; factory_rst_n = 0; sup_ok = 0; sup_lo = 0; req_ce = 1; req_we = 1;
    cyc(3); rst_n = 1; factory_rst_n = 1; #2;
    // R1
    chk("R1 wprot", wprot, 1); chk("R1 hiz", hiz, 1); chk("R1 bat", bat, 0);
    chk("R1 ce", mem_ce, 0); chk("R1 we", mem_we, 0);
    cyc(10);
    chk("R2 sealed no battery", bat, 0);
    sup_lo = 1; cyc(1); sup_ok = 1;
    cyc(2); chk("R10 not yet recovering", hiz, 1);
    cyc(1 + ENA - 1); chk("R6 still held", mem_ce, 0);
    cyc(2); chk("R6 enabled", mem_ce, 1);
    cyc(REC - ENA - 3); chk("R7 still protected", wprot, 1);
    cyc(2); chk("R7 released", wprot, 0);
    for (int p = 0; p < 4; p++) begin
      req_ce = p[0]; req_we = p[1]; cyc(1);
      chk("R9 ce pass", mem_ce, p[0]); chk("R9 we pass", mem_we, p[0] & p[1]);
    end
    req_ce = 1; req_we = 1;
    sup_ok = 0; cyc(2); chk("R4 not before third edge", wprot, 0);
    cyc(1); chk("R4 protect", wprot, 1); chk("R4 we", mem_we, 0); chk("R4 hiz", hiz, 1);
    sup_lo = 0; cyc(3); chk("R5 battery on", bat, 1);
    sup_lo = 1; cyc(3); chk("R5 battery off", bat, 0);
    sup_ok = 1; cyc(20); sup_ok = 0; cyc(4); chk("R8 fault in recovery", wprot, 1);
    sup_ok = 1; cyc(3 + REC - 1); chk("R8 restarted interval", wprot, 1);
    cyc(2); chk("R8 released", wprot, 0);
    sup_ok = 0; cyc(4); sup_lo = 0;
    rst_n = 0; cyc(2); rst_n = 1; cyc(4);
    chk("R3 seal survives reset", bat, 1);
    rst_n = 0; factory_rst_n = 0; cyc(2); rst_n = 1; factory_rst_n = 1; cyc(6);
    chk("R3 factory clears seal", bat, 0);
    chk("R2 sealed again", bat, 0);
    sup_lo = 1; cyc(1); sup_ok = 1; cyc(4); sup_ok = 0; cyc(2); sup_lo = 0; cyc(4);
    chk("R3 rearmed on first power", bat, 1);
  endtask

  initial begin
    fork
      begin : run_blk main_seq(); end
      begin : dog_blk
        cyc(100000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule